// File: doc/BRIEF.md
# Flash Bank Query and Identifier Read Formatter

This block builds the read word that a parallel NOR flash bank returns while it sits in its query mode or its identifier mode. The bank is made of one or more identical devices placed side by side on the data bus. The caller supplies three things: a bus byte offset, the access size in bytes, and the bank geometry. The geometry is the bank width, the width each device runs at, and each device's native width. From these the block works out which entry each device would answer with. It forms that device's answer and copies it into every device slot of the bank. It then stitches several bank-wide answers together when an access is wider than the bank.

Query bytes come from an 82-entry table held in registers. The reset loads this table from the block's parameters, which give the blocks per device, the bytes per block and the write-buffer size. Identifier reads return a 16-bit manufacturer code and a 16-bit device code, both set by parameters. The bank width, device width and native width are normally strapped. When the device width is set to zero, the block falls back to a simple scheme: it uses only the low offset byte and returns a single answer with no lane replication.

A two-state controller captures the formatted word on a read strobe. It presents that word, with a valid flag, in the following cycle. States: `ST_IDLE` (no result pending) and `ST_RESP` (a result is valid). Transitions: `ST_IDLE -> ST_RESP` on a strobe, `ST_RESP -> ST_RESP` on a back-to-back strobe, `ST_RESP -> ST_IDLE` when no strobe comes, and `ST_IDLE -> ST_IDLE` when idle.

Top module: `cfi_query_formatter`

## Requirements
- R1: A strobe sampled at a clock edge moves the controller to `ST_RESP`, so `rd_valid` is 1 for the cycle after that edge. `rd_data` takes the formatted word at that same edge and keeps it until the next strobe. Without a strobe, `rd_valid` returns to 0.
- R2: When the device width D is not 0, lane group g uses the offset `off + g*B`, taken modulo 2^ADDR_W. Its table index is that offset shifted right by log2(B) + log2(M) - log2(D), where B is the bank width and M is the native width.
- R3: A query index of 0x52 or above yields zero for that lane group.
- R4: The table holds the following bytes, and every other index below 0x52 holds 0x00:
  - 0x10, 0x11, 0x12: 0x51, 0x52, 0x59
  - 0x13: 0x01, and 0x15: 0x31
  - 0x1B: 0x45, and 0x1C: 0x55
  - 0x1F: 0x07, 0x20: 0x07, and 0x21: 0x0A
  - 0x23, 0x24, 0x25: 0x04
  - 0x27: log2(blocks*block bytes)
  - 0x28: 0x02
  - 0x2A: the write-buffer log2
  - 0x2C: 0x01
  - 0x2D and 0x2E: blocks-1, low byte then high byte
  - 0x2F and 0x30: block bytes shifted right by 8 and by 16
  - 0x31 to 0x35: 0x50, 0x52, 0x49, 0x31, 0x30
  - 0x3F: 0x01
- R5: In query mode with D=1 and M>1, every byte of the device's answer carries the query byte. The byte is repeated, not zero-padded.
- R6: In query mode with D not equal to M and D not 1, the lane group reads zero.
- R7: The low D bytes of a device's answer are copied into every D-byte slot of the B-byte lane group. When D equals M in query mode, the answer is the query byte zero-extended to D bytes.
- R8: In identifier mode, bits 7:0 of the index select the answer. 0x00 gives the manufacturer code, 0x01 gives the device code, and any other value gives zero. The answer is then replicated as in R7.
- R9: When the access is A bytes, every lane group g with g*B < A is placed at byte g*B of the word. An access narrower than B uses group 0 alone.
- R10: Bytes at and above the access size A read as zero.
- R11: When D=0 in query mode, the index is offset[7:0] shifted right by log2(B). The result is the table byte zero-extended, or zero if the index is 0x52 or above.
- R12: When D=0 in identifier mode, the index is computed as in R11. Index 0 gives {mfr[7:0], dev[7:0]}, index 1 gives {mfr[15:8], dev[15:8]}, and any other index gives zero.
- R13: During and right after reset, `rd_valid` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also loads the query table |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| rd_ident | input | 1 | 1 = identifier mode, 0 = query mode |
| rd_offset | input | ADDR_W | Bus byte offset of the access |
| rd_bytes | input | 3 | Access size in bytes (1, 2 or 4) |
| cfg_bank_bytes | input | 3 | Bank width B in bytes (1, 2 or 4) |
| cfg_dev_bytes | input | 3 | Device width D in bytes (0 = unset, 1, 2 or 4; D <= B) |
| cfg_max_bytes | input | 3 | Native device width M in bytes (D <= M <= 4) |
| rd_valid | output | 1 | Result valid in the cycle after a strobe |
| rd_data | output | 32 | Formatted read word |

## Verification
Every result is due exactly one clock edge after the edge that samples its strobe. The bench drives the strobe and all of its operands on a falling edge. It reads `rd_valid` and `rd_data` on the next falling edge, which is half a cycle after the capturing edge. One falling edge later, with the strobe low, the bench confirms that `rd_valid` has dropped and `rd_data` has not moved. No check ever lands on the edge where the value changes.

// File: rtl/cfi_fmt_pkg.sv
package cfi_fmt_pkg;

    localparam int unsigned TBL_LEN  = 82;
    localparam int unsigned IDX_W    = 7;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned LANES    = DATA_W / 8;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } fmt_state_e;

    // log2 of a byte count restricted to 1, 2 or 4
    function automatic logic [1:0] lg2b(input logic [2:0] n);
        unique case (n)
            3'd2:    return 2'd1;
            3'd4:    return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    // reset value of one query table entry
    function automatic logic [7:0] tbl_init(
        input int unsigned idx,
        input int unsigned blocks,
        input int unsigned blk_bytes,
        input int unsigned size_log2,
        input int unsigned wbuf_log2
    );
        logic [31:0] bm1;
        logic [31:0] bb;
        bm1 = 32'(blocks - 1);
        bb  = 32'(blk_bytes);
        case (idx)
            'h10: return 8'h51;
            'h11: return 8'h52;
            'h12: return 8'h59;
            'h13: return 8'h01;
            'h15: return 8'h31;
            'h1B: return 8'h45;
            'h1C: return 8'h55;
            'h1F: return 8'h07;
            'h20: return 8'h07;
            'h21: return 8'h0A;
            'h23: return 8'h04;
            'h24: return 8'h04;
            'h25: return 8'h04;
            'h27: return 8'(size_log2);
            'h28: return 8'h02;
            'h2A: return 8'(wbuf_log2);
            'h2C: return 8'h01;
            'h2D: return bm1[7:0];
            'h2E: return bm1[15:8];
            'h2F: return bb[15:8];
            'h30: return bb[23:16];
            'h31: return 8'h50;
            'h32: return 8'h52;
            'h33: return 8'h49;
            'h34: return 8'h31;
            'h35: return 8'h30;
            'h3F: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfi_fmt_table.sv
module cfi_fmt_table
    import cfi_fmt_pkg::*;
#(
    parameter int unsigned NRD        = 5,
    parameter int unsigned BLOCKS     = 128,
    parameter int unsigned BLK_BYTES  = 65536,
    parameter int unsigned WBUF_LOG2  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
    output logic [NRD-1:0][7:0]        rd_byte
);

    localparam int unsigned SIZE_LOG2 = $clog2(BLOCKS * BLK_BYTES);

    logic [7:0] tbl_q [TBL_LEN];

    // contents are loaded while reset is held and never written otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(TBL_LEN); i++) begin
                tbl_q[i] <= tbl_init(i, BLOCKS, BLK_BYTES, SIZE_LOG2, WBUF_LOG2);
            end
        end
    end

    generate
        for (genvar p = 0; p < int'(NRD); p++) begin : g_port
            always_comb begin
                if (32'(rd_idx[p]) < TBL_LEN) begin
                    rd_byte[p] = tbl_q[rd_idx[p]];
                end else begin
                    rd_byte[p] = 8'h00;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cfi_fmt_lane.sv
module cfi_fmt_lane
    import cfi_fmt_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned LANE     = 0,
    parameter logic [15:0] MFR_CODE = 16'h00A7,
    parameter logic [15:0] DEV_CODE = 16'h2251
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic              ident,
    input  logic [2:0]        bank_b,
    input  logic [2:0]        dev_b,
    input  logic [2:0]        max_b,
    input  logic [2:0]        acc_b,
    output logic [IDX_W-1:0]  tbl_idx,
    input  logic [7:0]        tbl_byte,
    output logic [DATA_W-1:0] lane_word,
    output logic              lane_en
);

    logic [ADDR_W-1:0] lane_off;
    logic [2:0]        shamt;
    logic [ADDR_W-1:0] idx_full;
    logic              in_range;
    logic [31:0]       dev_ans;
    logic [31:0]       rep;
    logic [31:0]       trunc;
    logic [6:0]        byte_pos;
    logic [6:0]        bit_pos;

    always_comb begin
        lane_off = offset + (ADDR_W'(LANE) * ADDR_W'(bank_b));
        shamt    = {1'b0, lg2b(bank_b)} + {1'b0, lg2b(max_b)} - {1'b0, lg2b(dev_b)};
        idx_full = lane_off >> shamt;
        in_range = idx_full < ADDR_W'(TBL_LEN);
        tbl_idx  = idx_full[IDX_W-1:0];
    end

    // answer of a single device before lane replication
    always_comb begin
        dev_ans = 32'h0;
        if (ident) begin
            unique case (idx_full[7:0])
                8'h00:   dev_ans = {16'h0, MFR_CODE};
                8'h01:   dev_ans = {16'h0, DEV_CODE};
                default: dev_ans = 32'h0;
            endcase
        end else if (in_range) begin
            if (dev_b == max_b) begin
                dev_ans = {24'h0, tbl_byte};
            end else if (dev_b == 3'd1 && bank_b <= 3'd4) begin
                dev_ans = {4{tbl_byte}};
            end else begin
                dev_ans = 32'h0;
            end
        end
    end

    // copy the device slot across the bank, then keep B bytes
    always_comb begin
        unique case (dev_b)
            3'd1:    rep = {4{dev_ans[7:0]}};
            3'd2:    rep = {2{dev_ans[15:0]}};
            default: rep = dev_ans;
        endcase
        unique case (bank_b)
            3'd1:    trunc = {24'h0, rep[7:0]};
            3'd2:    trunc = {16'h0, rep[15:0]};
            default: trunc = rep;
        endcase
    end

    always_comb begin
        byte_pos = 7'(LANE) * 7'(bank_b);
        bit_pos  = {byte_pos[3:0], 3'b000};
        lane_en  = byte_pos < 7'(acc_b);
        if (!lane_en || byte_pos >= 7'd4) begin
            lane_word = '0;
        end else begin
            lane_word = trunc << bit_pos[4:0];
        end
    end

endmodule

// File: rtl/cfi_fmt_legacy.sv
module cfi_fmt_legacy
    import cfi_fmt_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter logic [15:0] MFR_CODE = 16'h00A7,
    parameter logic [15:0] DEV_CODE = 16'h2251
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic              ident,
    input  logic [2:0]        bank_b,
    output logic [IDX_W-1:0]  tbl_idx,
    input  logic [7:0]        tbl_byte,
    output logic [DATA_W-1:0] word
);

    logic [7:0] idx;

    always_comb begin
        idx     = offset[7:0] >> lg2b(bank_b);
        tbl_idx = idx[IDX_W-1:0];
        if (ident) begin
            unique case (idx)
                8'h00:   word = {16'h0, MFR_CODE[7:0], DEV_CODE[7:0]};
                8'h01:   word = {16'h0, MFR_CODE[15:8], DEV_CODE[15:8]};
                default: word = '0;
            endcase
        end else if (32'(idx) < TBL_LEN) begin
            word = {24'h0, tbl_byte};
        end else begin
            word = '0;
        end
    end

endmodule

// File: rtl/cfi_query_formatter.sv
module cfi_query_formatter
    import cfi_fmt_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned BLOCKS    = 128,
    parameter int unsigned BLK_BYTES = 65536,
    parameter int unsigned WBUF_LOG2 = 8,
    parameter logic [15:0] MFR_CODE  = 16'h00A7,
    parameter logic [15:0] DEV_CODE  = 16'h2251
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              rd_ident,
    input  logic [ADDR_W-1:0] rd_offset,
    input  logic [2:0]        rd_bytes,
    input  logic [2:0]        cfg_bank_bytes,
    input  logic [2:0]        cfg_dev_bytes,
    input  logic [2:0]        cfg_max_bytes,
    output logic              rd_valid,
    output logic [31:0]       rd_data
);

    localparam int unsigned NRD = LANES + 1;

    fmt_state_e state_q;
    fmt_state_e state_d;

    logic [NRD-1:0][IDX_W-1:0] tbl_idx;
    logic [NRD-1:0][7:0]       tbl_byte;
    logic [LANES-1:0][31:0]    lane_word;
    logic [LANES-1:0]          lane_en;
    logic [31:0]               legacy_word;
    logic [31:0]               merged;
    logic [31:0]               fmt_word;
    logic [31:0]               data_q;

    cfi_fmt_table #(
        .NRD       (NRD),
        .BLOCKS    (BLOCKS),
        .BLK_BYTES (BLK_BYTES),
        .WBUF_LOG2 (WBUF_LOG2)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (tbl_idx),
        .rd_byte (tbl_byte)
    );

    generate
        for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
            cfi_fmt_lane #(
                .ADDR_W   (ADDR_W),
                .LANE     (g),
                .MFR_CODE (MFR_CODE),
                .DEV_CODE (DEV_CODE)
            ) u_lane (
                .offset    (rd_offset),
                .ident     (rd_ident),
                .bank_b    (cfg_bank_bytes),
                .dev_b     (cfg_dev_bytes),
                .max_b     (cfg_max_bytes),
                .acc_b     (rd_bytes),
                .tbl_idx   (tbl_idx[g]),
                .tbl_byte  (tbl_byte[g]),
                .lane_word (lane_word[g]),
                .lane_en   (lane_en[g])
            );
        end
    endgenerate

    cfi_fmt_legacy #(
        .ADDR_W   (ADDR_W),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_legacy (
        .offset   (rd_offset),
        .ident    (rd_ident),
        .bank_b   (cfg_bank_bytes),
        .tbl_idx  (tbl_idx[LANES]),
        .tbl_byte (tbl_byte[LANES]),
        .word     (legacy_word)
    );

    // merge lane groups, pick the path, mask to the access size
    always_comb begin
        merged = '0;
        for (int g = 0; g < int'(LANES); g++) begin
            if (lane_en[g]) begin
                merged = merged | lane_word[g];
            end
        end
        fmt_word = (cfg_dev_bytes == 3'd0) ? legacy_word : merged;
        unique case (rd_bytes)
            3'd1:    fmt_word = fmt_word & 32'h0000_00FF;
            3'd2:    fmt_word = fmt_word & 32'h0000_FFFF;
            default: fmt_word = fmt_word;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_stb ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_stb ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_stb) begin
            data_q <= fmt_word;
        end
    end

    // outputs
    always_comb begin
        rd_valid = (state_q == ST_RESP);
        rd_data  = data_q;
    end

    AST_VALID_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);  // R1
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rd_valid);  // R1
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));  // R1
    AST_BYTE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_bytes == 3'd1) |=> (rd_data[31:8] == 24'h0));  // R10
    AST_NARROW_UNSUP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !rd_ident && cfg_dev_bytes != 3'd0 && cfg_dev_bytes != 3'd1
         && cfg_dev_bytes != cfg_max_bytes) |=> (rd_data == 32'h0));  // R6
    AST_LEGACY_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_ident && cfg_dev_bytes == 3'd0 && cfg_bank_bytes == 3'd1
         && rd_offset[7:0] >= 8'd2) |=> (rd_data == 32'h0));  // R12

endmodule

// File: tb/tb_cfi_query_formatter.sv
module tb_cfi_query_formatter;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam logic [15:0] MFR = 16'h00A7;
    localparam logic [15:0] DEV = 16'h2251;
    localparam int BLOCKS     = 128;
    localparam int BLK_BYTES  = 65536;
    localparam int WBUF_LOG2  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_stb = 1'b0;
    logic              rd_ident = 1'b0;
    logic [ADDR_W-1:0] rd_offset = '0;
    logic [2:0]        rd_bytes = 3'd1;
    logic [2:0]        cfg_bank_bytes = 3'd1;
    logic [2:0]        cfg_dev_bytes = 3'd1;
    logic [2:0]        cfg_max_bytes = 3'd1;
    logic              rd_valid;
    logic [31:0]       rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfi_query_formatter #(
        .ADDR_W    (ADDR_W),
        .BLOCKS    (BLOCKS),
        .BLK_BYTES (BLK_BYTES),
        .WBUF_LOG2 (WBUF_LOG2),
        .MFR_CODE  (MFR),
        .DEV_CODE  (DEV)
    ) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_stb         (rd_stb),
        .rd_ident       (rd_ident),
        .rd_offset      (rd_offset),
        .rd_bytes       (rd_bytes),
        .cfg_bank_bytes (cfg_bank_bytes),
        .cfg_dev_bytes  (cfg_dev_bytes),
        .cfg_max_bytes  (cfg_max_bytes),
        .rd_valid       (rd_valid),
        .rd_data        (rd_data)
    );

    // table contents as listed in R4
    function automatic logic [7:0] tbl(input int idx);
        int bm1;
        bm1 = BLOCKS - 1;
        case (idx)
            16: return 8'h51;  17: return 8'h52;  18: return 8'h59;
            19: return 8'h01;  21: return 8'h31;
            27: return 8'h45;  28: return 8'h55;
            31: return 8'h07;  32: return 8'h07;  33: return 8'h0A;
            35: return 8'h04;  36: return 8'h04;  37: return 8'h04;
            39: return 8'd23;  40: return 8'h02;  42: return 8'(WBUF_LOG2);
            44: return 8'h01;
            45: return 8'(bm1 % 256);
            46: return 8'(bm1 / 256);
            47: return 8'((BLK_BYTES / 256) % 256);
            48: return 8'((BLK_BYTES / 65536) % 256);
            49: return 8'h50;  50: return 8'h52;  51: return 8'h49;
            52: return 8'h31;  53: return 8'h30;  63: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    // byte-by-byte expected word from R2..R12
    function automatic logic [31:0] exp_word(input bit ident, input int off,
                                             input int w, input int b,
                                             input int d, input int m);
        logic [31:0] r;
        logic [31:0] ans;
        r = 32'h0;
        if (d == 0) begin
            int idx;
            idx = (off % 256) / b;
            ans = 32'h0;
            if (ident) begin
                if (idx == 0) ans = {16'h0, MFR[7:0], DEV[7:0]};
                else if (idx == 1) ans = {16'h0, MFR[15:8], DEV[15:8]};
            end else if (idx < 82) begin
                ans = {24'h0, tbl(idx)};
            end
            for (int k = 0; k < w; k++) r[8*k +: 8] = ans[8*k +: 8];
        end else begin
            for (int k = 0; k < w; k++) begin
                int g, j, s, loff, idx;
                logic [7:0] bv;
                g = k / b; j = k % b; s = j % d;
                loff = (off + g * b) % 65536;
                idx = loff / (b * m / d);
                bv = 8'h00;
                if (ident) begin
                    logic [15:0] code;
                    code = ((idx % 256) == 0) ? MFR : (((idx % 256) == 1) ? DEV : 16'h0);
                    if (s < 2) bv = code[8*s +: 8];
                end else if (idx < 82) begin
                    if (d == m) bv = (s == 0) ? tbl(idx) : 8'h00;
                    else if (d == 1) bv = tbl(idx);
                end
                r[8*k +: 8] = bv;
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // drive one read on a falling edge, sample on the next falling edge
    task automatic do_read(input string req, input bit ident, input int off,
                           input int w, input int b, input int d, input int m);
        logic [31:0] e;
        e = exp_word(ident, off, w, b, d, m);
        @(negedge clk);
        rd_stb = 1'b1; rd_ident = ident; rd_offset = ADDR_W'(off);
        rd_bytes = 3'(w); cfg_bank_bytes = 3'(b);
        cfg_dev_bytes = 3'(d); cfg_max_bytes = 3'(m);
        @(negedge clk);
        rd_stb = 1'b0;
        check({req, " valid"}, {31'h0, rd_valid}, 32'h1);
        check(req, rd_data, e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R13 valid in reset", {31'h0, rd_valid}, 32'h0);
        check("R13 data in reset", rd_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13 valid after reset", {31'h0, rd_valid}, 32'h0);
        check("R13 data after reset", rd_data, 32'h0);

        do_read("R4 Q byte", 0, 'h10, 1, 1, 1, 1);
        @(negedge clk);
        check("R1 valid drops", {31'h0, rd_valid}, 32'h0);
        check("R1 data held", rd_data, 32'h51);
        do_read("R4 version digit", 0, 'h35, 1, 1, 1, 1);
        do_read("R4 size log2", 0, 'h27, 1, 1, 1, 1);
        do_read("R4 erase region", 0, 'h2D, 4, 1, 1, 1);
        do_read("R3 index 0x52", 0, 'h52, 1, 1, 1, 1);
        do_read("R3 index far", 0, 'h1234, 1, 1, 1, 1);
        do_read("R2 R7 x16 bank", 0, 'h20, 2, 2, 2, 2);
        do_read("R9 two groups", 0, 'h20, 4, 2, 2, 2);
        do_read("R5 x8 of x16", 0, 'h40, 2, 2, 1, 2);
        do_read("R5 x8 of x32 in x32 bank", 0, 'h80, 4, 4, 1, 4);
        do_read("R6 unsupported narrow", 0, 'h40, 4, 4, 2, 4);
        do_read("R8 mfr code", 1, 'h0, 4, 4, 2, 2);
        do_read("R8 dev code", 1, 'h4, 4, 4, 2, 2);
        do_read("R8 other index", 1, 'h8, 4, 4, 2, 2);
        do_read("R8 low byte only", 1, 'h101, 2, 1, 1, 1);
        do_read("R10 mask one byte", 1, 'h0, 1, 4, 4, 4);
        do_read("R10 mask two bytes", 1, 'h4, 2, 4, 4, 4);
        do_read("R11 legacy query", 0, 'h20, 2, 2, 0, 0);
        do_read("R11 legacy low byte", 0, 'h120, 4, 2, 0, 0);
        do_read("R11 legacy beyond", 0, 'h1A4, 4, 2, 0, 0);
        do_read("R12 legacy id 0", 1, 'h0, 4, 4, 0, 0);
        do_read("R12 legacy id 1", 1, 'h4, 4, 4, 0, 0);
        do_read("R12 legacy id other", 1, 'h108, 4, 4, 0, 0);

        // back-to-back strobes
        do_read("R1 back to back a", 0, 'h11, 1, 1, 1, 1);
        do_read("R1 back to back b", 0, 'h12, 1, 1, 1, 1);

        void'($urandom(32'd20240611));
        for (int n = 0; n < 400; n++) begin
            int b, d, m, w, off, span;
            bit idm;
            b = 1 << ($urandom % 3);
            case ($urandom % 4)
                0: d = 0;
                1: d = 1;
                2: d = (b >= 2) ? 2 : 1;
                default: d = b;
            endcase
            if (d == 0) m = 0;
            else begin
                m = d << ($urandom % 3);
                if (m > 4) m = 4;
            end
            w = 1 << ($urandom % 3);
            idm = 1'($urandom % 2);
            span = (d == 0) ? 512 : 96 * (b * m / d);
            off = ($urandom % 8 == 0) ? int'($urandom % 32768) : int'($urandom % span);
            do_read("R2 R7 R9 random", idm, off, w, b, d, m);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule